// File: doc/BRIEF.md
# Bit-To-ASCII Serial Character Framer

The framer turns each single-bit sample from a bit generator into one asynchronous serial character on a transmit line. A sample of 0 leaves as the ASCII character `'0'` and a sample of 1 as `'1'`. A plain terminal on the far end therefore shows the generator's output stream as readable digits. The line runs at one bit time per baud tick, where 2400 baud is the intended rate. The baud tick comes from outside as a one-clock-cycle enable.

All timing comes from a free-running slot counter that steps once per baud tick. Sixteen slots make one character period. Ten consecutive slots carry the framed character, and the line idles high in the other six. A format select picks one of two layouts:

- 8 data bits, no parity, 1 stop bit.
- 7 data bits, no parity, 2 stop bits. The eighth data slot then becomes a second stop slot.

When the counter wraps, the block issues a one-cycle advance strobe. This strobe tells the generator to present its next bit, so the sample never changes while a frame is on the line.

Top module: `bta_uart_framer`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block clears the slot counter to 0 and drives `tx` high and `adv_stb` low.
- R2: The slot counter and `tx` change only on a clock edge where `baud_tick` is high. With no tick, `tx` holds its level.
- R3: In slots 0 to 3, 14 and 15, `tx` is high (idle).
- R4: In slot 4, `tx` is low. This is the start bit, and it is the first low level after the idle slots.
- R5: In 8-N-1 format (`fmt_sel` = 0), slots 5 to 12 carry the byte 0x30 OR the sample, least significant bit first. That gives 0,0,0,0,1,1,0,0 for a sample of 0 and 1,0,0,0,1,1,0,0 for a sample of 1.
- R6: In 8-N-1 format, slot 13 is a single stop bit, driven high. Slot 12 carries data bit 7, which is low.
- R7: In 7-N-2 format (`fmt_sel` = 1), slots 5 to 11 carry the low seven bits of 0x30 OR the sample, least significant bit first. Slots 12 and 13 are both high as two stop bits.
- R8: `data_bit` and `fmt_sel` are captured on the tick that moves the counter from slot 3 to slot 4. Changes to them later in the frame have no effect on that frame.
- R9: `adv_stb` is high for exactly one clock cycle. That cycle directly follows the tick that moves the counter from slot 15 to slot 0, which is the falling edge of the counter's top bit. The pulse occurs once per 16 ticks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| baud_tick | input | 1 | One-cycle enable, once per bit time |
| data_bit | input | 1 | Generator sample to be sent as '0' or '1' |
| fmt_sel | input | 1 | 0 selects 8-N-1, 1 selects 7-N-2 |
| tx | output | 1 | Serial transmit line, idle high |
| adv_stb | output | 1 | One-cycle request for the next generator sample |

## Verification
The assertions check several rules on every cycle:

- The line holds its level between ticks.
- The line is high in the idle slots, low in the start slot, and high in the second stop slot in 7-N-2.
- The captured sample and format stay stable away from the capture tick.
- The advance strobe is one cycle wide and lands on slot 0.

Only the bench's scenarios show the values that need the whole frame to be seen:

- The decoded character value for each sample and format.
- The single stop bit of 8-N-1.
- That late changes to the inputs do not reach the frame already on the line.
- That the strobe recurs once every sixteen ticks.

// File: rtl/bta_pkg.sv
// Package: shared constants and types for the bit-to-ASCII framer.
// Assumes a frame of start + 8 slots + 1 stop = 10 slots.
package bta_pkg;

    // Frame-format selector encoding
    typedef enum logic {
        FMT_8N1 = 1'b0,
        FMT_7N2 = 1'b1
    } fmt_e;

    // Number of line slots one framed character occupies
    localparam int FRAME_LEN = 10;

    // Character for a zero sample; a one sample sets bit 0
    localparam logic [7:0] CHAR_BASE = 8'h30;

    // Line level pattern for a frame, index 0 = start slot
    typedef logic [FRAME_LEN-1:0] frame_t;

    // Build the full line pattern for one sample and format
    function automatic frame_t build_frame(input logic sample, input fmt_e fmt);
        frame_t      f;
        logic [7:0]  ch;
        ch           = CHAR_BASE | {7'b0, sample};
        f[0]         = 1'b0;            // start bit
        f[8:1]       = ch;              // data, LSB first
        if (fmt == FMT_7N2) begin
            f[8]     = 1'b1;            // eighth data slot becomes stop
        end
        f[9]         = 1'b1;            // final stop bit
        return f;
    endfunction

endpackage

// File: rtl/bta_slot_ctr.sv
// Module: free-running slot counter.
// Steps once per baud tick and wraps after 2**W slots. Also gives
// the value the counter takes on the next tick, so downstream
// registers can line up with the counter.
// Assumes baud_tick is a single-cycle enable.
module bta_slot_ctr #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    output logic [W-1:0] slot,
    output logic [W-1:0] slot_nxt
);

    logic [W-1:0] slot_q;

    // Next value is simply one ahead, wrapping naturally
    assign slot_nxt = slot_q + W'(1);
    assign slot     = slot_q;

    // Advance the counter on each tick
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q <= '0;
        end else if (tick) begin
            slot_q <= slot_nxt;
        end
    end

endmodule

// File: rtl/bta_frame_shaper.sv
// Module: captures the sample and format at frame start and drives
// the registered transmit level for each slot.
// Assumes FIRST + FRAME_LEN - 1 fits in the slot counter range.
module bta_frame_shaper
    import bta_pkg::*;
#(
    parameter int W     = 4,
    parameter int FIRST = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic [W-1:0] slot_nxt,
    input  logic         sample_in,
    input  logic         fmt_in,
    output logic         sample_q,
    output logic         fmt_q,
    output logic         tx
);

    localparam logic [W-1:0] FIRST_S = W'(FIRST);
    localparam logic [W-1:0] LAST_S  = W'(FIRST + FRAME_LEN - 1);

    logic         in_frame;
    logic [W-1:0] offset;
    logic         level;
    logic         tx_q;
    frame_t       pattern;

    // Capture happens on the tick that enters the start slot
    logic capture;
    assign capture = tick && (slot_nxt == FIRST_S);

    // Hold the sample and format for the whole frame
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sample_q <= 1'b0;
            fmt_q    <= 1'b0;
        end else if (capture) begin
            sample_q <= sample_in;
            fmt_q    <= fmt_in;
        end
    end

    // Select the line level for the slot about to begin
    always_comb begin
        pattern  = build_frame(sample_q, fmt_e'(fmt_q));
        in_frame = (slot_nxt >= FIRST_S) && (slot_nxt <= LAST_S);
        offset   = slot_nxt - FIRST_S;
        level    = 1'b1;
        for (int i = 0; i < FRAME_LEN; i++) begin
            if (in_frame && (offset == W'(i))) begin
                level = pattern[i];
            end
        end
    end

    // Register the line level so tx changes only on a tick edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_q <= 1'b1;
        end else if (tick) begin
            tx_q <= level;
        end
    end

    assign tx = tx_q;

endmodule

// File: rtl/bta_adv_pulse.sv
// Module: forms the generator advance strobe from the falling edge of
// the slot counter's top bit, as one registered cycle.
// Assumes ticks are at least one cycle apart or steady; either way the
// pulse lasts one cycle.
module bta_adv_pulse (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic msb_now,
    input  logic msb_nxt,
    output logic adv
);

    logic adv_q;

    // Pulse when the top bit is about to fall on this tick
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            adv_q <= 1'b0;
        end else begin
            adv_q <= tick && msb_now && !msb_nxt;
        end
    end

    assign adv = adv_q;

endmodule

// File: rtl/bta_uart_framer.sv
// Module: top of the bit-to-ASCII serial framer.
// Sends each generator sample as '0'/'1' in a 16-slot character period
// and requests the next sample on the counter wrap.
// Assumes baud_tick is a one-cycle enable at the bit rate.
module bta_uart_framer #(
    parameter int SLOT_W     = 4,
    parameter int FIRST_SLOT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic baud_tick,
    input  logic data_bit,
    input  logic fmt_sel,
    output logic tx,
    output logic adv_stb
);

    logic [SLOT_W-1:0] slot_q;
    logic [SLOT_W-1:0] slot_nxt;
    logic              dat_q;
    logic              fmt_q;

    bta_slot_ctr #(.W(SLOT_W)) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (baud_tick),
        .slot     (slot_q),
        .slot_nxt (slot_nxt)
    );

    bta_frame_shaper #(.W(SLOT_W), .FIRST(FIRST_SLOT)) u_shape (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (baud_tick),
        .slot_nxt  (slot_nxt),
        .sample_in (data_bit),
        .fmt_in    (fmt_sel),
        .sample_q  (dat_q),
        .fmt_q     (fmt_q),
        .tx        (tx)
    );

    bta_adv_pulse u_adv (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (baud_tick),
        .msb_now (slot_q[SLOT_W-1]),
        .msb_nxt (slot_nxt[SLOT_W-1]),
        .adv     (adv_stb)
    );

endmodule

// File: rtl/bta_uart_framer_chk.sv
// Checker: cycle-level rules of the framer, bound to the top module.
module bta_uart_framer_chk #(
    parameter int SLOT_W     = 4,
    parameter int FIRST_SLOT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  logic              tx,
    input  logic              adv_stb,
    input  logic [SLOT_W-1:0] cnt,
    input  logic              dat_q,
    input  logic              fmt_q
);

    localparam logic [SLOT_W-1:0] S_START = SLOT_W'(FIRST_SLOT);
    localparam logic [SLOT_W-1:0] S_PRE   = SLOT_W'(FIRST_SLOT - 1);
    localparam logic [SLOT_W-1:0] S_STOPA = SLOT_W'(FIRST_SLOT + 8);
    localparam logic [SLOT_W-1:0] S_LAST  = SLOT_W'(FIRST_SLOT + 9);

    // R2
    tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !baud_tick |=> $stable(tx));

    // R3
    idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((cnt < S_START) || (cnt > S_LAST)) |-> tx);

    // R4
    start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == S_START) |-> !tx);

    // R6
    last_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == S_LAST) |-> tx);

    // R7
    two_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fmt_q && (cnt == S_STOPA)) |-> tx);

    // R8
    capture_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(baud_tick && (cnt == S_PRE)) |=> ($stable(dat_q) && $stable(fmt_q)));

    // R9
    adv_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adv_stb |=> !adv_stb);

    // R9
    adv_place_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adv_stb |-> ((cnt == '0) && $past(baud_tick)));

endmodule

bind bta_uart_framer bta_uart_framer_chk #(
    .SLOT_W     (SLOT_W),
    .FIRST_SLOT (FIRST_SLOT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .baud_tick (baud_tick),
    .tx        (tx),
    .adv_stb   (adv_stb),
    .cnt       (slot_q),
    .dat_q     (dat_q),
    .fmt_q     (fmt_q)
);

// File: tb/sim_bta_uart_framer.sv
// Directed bench: a behavioural receiver decodes each character from
// the line, slot by slot, and compares with the expected ASCII value.
module sim_bta_uart_framer;

    localparam int DIV = 8;   // clock cycles per bit time in simulation

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic baud_tick;
    logic data_bit = 1'b0;
    logic fmt_sel = 1'b0;
    logic tx;
    logic adv_stb;
    logic tick_en = 1'b0;

    int   n_chk = 0;
    int   n_err = 0;
    int   slot = 0;        // bench model of the slot number
    bit   done = 1'b0;

    bta_uart_framer u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .baud_tick (baud_tick),
        .data_bit  (data_bit),
        .fmt_sel   (fmt_sel),
        .tx        (tx),
        .adv_stb   (adv_stb)
    );

    // 250 MHz clock: 4-unit period
    always #2 clk = ~clk;

    // Baud tick generator, driven on the falling edge
    initial begin
        int div_c;
        div_c     = 0;
        baud_tick = 1'b0;
        forever begin
            @(negedge clk);
            if (tick_en) begin
                div_c = div_c + 1;
                if (div_c == DIV) begin
                    baud_tick = 1'b1;
                    div_c     = 0;
                end else begin
                    baud_tick = 1'b0;
                end
            end else begin
                baud_tick = 1'b0;
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Wait for the next tick edge and sample just after it
    task automatic next_slot();
        @(posedge clk iff baud_tick == 1'b1);
        slot = (slot + 1) % 16;
        @(negedge clk);
    endtask

    task automatic go_to(input int s);
        while (slot != s) next_slot();
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        // R1 reset levels
        check(tx == 1'b1, "R1 tx after reset", int'(tx), 1);
        check(adv_stb == 1'b0, "R1 adv_stb after reset", int'(adv_stb), 0);
        rst_n = 1'b1;
        repeat (20) @(negedge clk);
        // R2 no tick, no change
        check(tx == 1'b1, "R2 tx without ticks", int'(tx), 1);
        #1 tick_en = 1'b1;
        // R1 counter at 0: fourth tick enters the start slot
        repeat (3) next_slot();
        check(tx == 1'b1, "R1 slot 3 still idle", int'(tx), 1);
        next_slot();
        check(tx == 1'b0, "R1 start after 4 ticks", int'(tx), 0);
    endtask

    // Receive one full 16-slot period and decode it
    task automatic t_frame(input logic d, input logic f);
        logic [15:0] lv;
        logic [7:0]  rx;
        logic [7:0]  exp_ch;
        int          st;
        go_to(15);
        data_bit = d;
        fmt_sel  = f;
        for (int s = 0; s < 16; s++) begin
            next_slot();
            lv[slot] = tx;
        end
        exp_ch = 8'h30 | {7'b0, d};
        // R3 idle slots
        check(lv[3:0] == 4'hF && lv[15:14] == 2'b11, "R3 idle slots high",
              int'({lv[15:14], lv[3:0]}), 63);
        st = -1;
        for (int i = 15; i >= 0; i--) if (!lv[i]) st = i;
        // R4 start position
        check(st == 4, "R4 start slot", st, 4);
        for (int i = 0; i < 8; i++) rx[i] = lv[5 + i];
        if (!f) begin
            // R5 decoded byte
            check(rx == exp_ch, "R5 8-N-1 byte", int'(rx), int'(exp_ch));
            // R6 stop bit
            check(lv[13] == 1'b1 && lv[12] == 1'b0, "R6 8-N-1 stop", int'(lv[13:12]), 2);
        end else begin
            // R7 seven bits plus two stops
            check(rx[6:0] == exp_ch[6:0], "R7 7-N-2 byte", int'(rx[6:0]), int'(exp_ch[6:0]));
            check(lv[13:12] == 2'b11, "R7 7-N-2 stops", int'(lv[13:12]), 3);
        end
    endtask

    // Inputs changed mid-frame must not alter the frame
    task automatic t_hold();
        logic [15:0] lv;
        go_to(2);
        data_bit = 1'b1;
        fmt_sel  = 1'b0;
        go_to(4);
        data_bit = 1'b0;
        fmt_sel  = 1'b1;
        for (int s = 5; s < 16; s++) begin
            next_slot();
            lv[slot] = tx;
        end
        // R8 sample and format held
        check(lv[5] == 1'b1, "R8 sample held", int'(lv[5]), 1);
        check(lv[12] == 1'b0, "R8 format held", int'(lv[12]), 0);
    endtask

    // Stall ticks inside a frame: line must not move
    task automatic t_stall();
        go_to(4);
        #1 tick_en = 1'b0;
        repeat (30) @(negedge clk);
        // R2 line held without ticks
        check(tx == 1'b0, "R2 start held during stall", int'(tx), 0);
        check(adv_stb == 1'b0, "R9 no strobe during stall", int'(adv_stb), 0);
        #1 tick_en = 1'b1;
    endtask

    // Advance strobe position, width and rate
    task automatic t_adv();
        int pulses;
        pulses = 0;
        for (int k = 0; k < 32; k++) begin
            next_slot();
            if (adv_stb) pulses++;
            check(adv_stb == (slot == 0), "R9 strobe on slot 0", int'(adv_stb), int'(slot == 0));
            @(negedge clk);
            check(adv_stb == 1'b0, "R9 strobe one cycle", int'(adv_stb), 0);
        end
        check(pulses == 2, "R9 once per 16 ticks", pulses, 2);
    endtask

    initial begin
        #400000;
        if (!done) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_frame(1'b0, 1'b0);
        t_frame(1'b1, 1'b0);
        t_frame(1'b0, 1'b1);
        t_frame(1'b1, 1'b1);
        t_hold();
        t_stall();
        t_adv();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule